// File: doc/BRIEF.md
# NAND Flash Bus Strobe Sequencer

This block places the strobes of one bus cycle on an 8-bit NAND flash style interface. A host hands it a single request: a command byte, an address byte, a data byte to write, or a data byte to read. The block then drives chip select, the command and address latch enables, write enable or read enable, and the data bus. Every edge is placed on a quarter-bus-clock grid. The block is clocked at four times the bus clock, so one tick of the fast clock is a quarter of a bus clock. All durations below are in ticks.

A six-bit timing word sets the cycle shape. Bits [2:0] hold a cycle-length value SCY (0..7). Bit [3] is a relaxed-timing flag. Bit [4] lengthens the write hold. Bit [5] selects the longer read-enable lead. Relaxed timing doubles the wait states, the chip-select lead and the sequence gaps. After a command, the block can wait out a settle period and then poll the ready/busy input. A bounded timeout ends that poll with an error. The timing word is captured when a request is accepted, so it may change while a cycle is in progress.

Top module: `nand_strobe_seq`

## Requirements
- R1: After reset, nf_cs_n, nf_we_n and nf_re_n are 1, nf_dq_oe, nf_cle, nf_ale, done and rd_valid are 0, and req_ready is 1.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both 1. req_ready is 0 from the cycle after acceptance until done. done is a single-cycle pulse per request.
- R3: The time from the fall of nf_cs_n to the fall of the strobe is 4 ticks, or 8 ticks when the relaxed bit [3] is 1. This holds when no gap applies.
- R4: For a write request (req_kind 0 = command, 1 = address, 2 = data write), nf_we_n stays low for 4*(1+W) ticks. W = SCY, or 2*SCY when relaxed.
- R5: After nf_we_n rises, nf_cs_n stays low and the data bus stays driven (nf_dq_oe = 1) for a hold set by {bit3, bit4}: 2, 4, 6 or 8 ticks for 00, 01, 10 and 11. done coincides with the rise of nf_cs_n.
- R6: For a read request (req_kind 3), nf_re_n stays low for L + 4*W ticks. The lead L is set by {bit3, bit5}: 3, 4, 2 or 4 ticks for 00, 01, 10 and 11.
- R7: After nf_re_n rises on a read, nf_cs_n stays low for 4 ticks, or 8 when relaxed. The data bus is not driven during a read.
- R8: rd_data holds the nf_dq_in value present just before the edge where nf_re_n rises. rd_valid is high for exactly one cycle, in the cycle that begins at that edge.
- R9: The first data request (kind 2 or 3) after a command or address request has an extra gap of 16*(2+SCY) ticks before the chip-select lead, or 32*(2+SCY) when relaxed. A data request that follows a data request has no gap.
- R10: During a write, nf_cle is 1 only for command requests and nf_ale only for address requests. nf_dq_out carries the byte accepted with the request.
- R11: A command with req_rb_wait set releases nf_cs_n and then keeps all strobes idle. nf_rb is ignored for D = 32*(2+SCY) ticks (64*(2+SCY) relaxed). With nf_rb high, done rises D+1 ticks after nf_cs_n rises.
- R12: If nf_rb stays low, polling ends after TO_TICKS ticks. done and timeout_err pulse together D+TO_TICKS ticks after nf_cs_n rises.
- R13: nf_we_n and nf_re_n are never low together, and neither is low while nf_cs_n is high.
- R14: Changing cfg_i after acceptance does not alter the timing of the cycle in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, four ticks per bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_i | input | 6 | Timing word: [2:0] SCY, [3] relaxed, [4] write hold, [5] read lead |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_kind | input | 2 | 0 command, 1 address, 2 data write, 3 data read |
| req_wdata | input | DW | Byte for command, address or write |
| req_rb_wait | input | 1 | After a command, wait for ready/busy |
| done | output | 1 | One-cycle end-of-request pulse |
| timeout_err | output | 1 | Ready/busy poll timed out, with done |
| rd_data | output | DW | Captured read byte |
| rd_valid | output | 1 | rd_data updated |
| nf_cs_n | output | 1 | Chip select, active low |
| nf_we_n | output | 1 | Write enable, active low |
| nf_re_n | output | 1 | Read enable, active low |
| nf_cle | output | 1 | Command latch enable |
| nf_ale | output | 1 | Address latch enable |
| nf_dq_out | output | DW | Bus data out |
| nf_dq_oe | output | 1 | Bus output enable |
| nf_dq_in | input | DW | Bus data in |
| nf_rb | input | 1 | Ready/busy, 1 = ready |

## Verification
The assertions assume that req_kind, req_wdata and req_rb_wait are stable in the cycle a request is accepted. They also assume that nf_rb and nf_dq_in carry known levels. The bench offers each request for exactly one cycle while the sequencer is idle and waits for done before offering the next. It holds nf_dq_in and nf_rb at fixed levels for the whole request. When it changes cfg_i mid-cycle, it does so only after the accepting edge. This keeps every measured edge a deterministic function of the captured timing word.

// File: rtl/nfs_pkg.sv
package nfs_pkg;
  localparam int TW = 12;

  typedef enum logic [1:0] {K_CMD = 2'd0, K_ADDR = 2'd1, K_WDATA = 2'd2, K_RDATA = 2'd3} kind_e;
  typedef enum logic [2:0] {S_IDLE, S_GAP, S_SETUP, S_STROBE, S_HOLD, S_RBWAIT, S_RBPOLL} st_e;

  typedef struct packed {
    logic       rd_lead;
    logic       wr_hold;
    logic       relax;
    logic [2:0] cyc_len;
  } tcfg_t;

  function automatic logic [TW-1:0] f_waits(tcfg_t c);
    int w;
    w = int'(c.cyc_len);
    return TW'(c.relax ? 2 * w : w);
  endfunction

  function automatic logic [TW-1:0] f_cs_lead(tcfg_t c);
    return c.relax ? TW'(8) : TW'(4);
  endfunction

  function automatic logic [TW-1:0] f_we_low(tcfg_t c);
    return TW'(4 * (1 + int'(f_waits(c))));
  endfunction

  function automatic logic [TW-1:0] f_we_hold(tcfg_t c);
    return TW'(2 * (1 + int'({c.relax, c.wr_hold})));
  endfunction

  function automatic logic [TW-1:0] f_re_lead(tcfg_t c);
    logic [TW-1:0] l;
    unique case ({c.relax, c.rd_lead})
      2'b00:   l = TW'(3);
      2'b10:   l = TW'(2);
      default: l = TW'(4);
    endcase
    return l;
  endfunction

  function automatic logic [TW-1:0] f_re_low(tcfg_t c);
    return TW'(int'(f_re_lead(c)) + 4 * int'(f_waits(c)));
  endfunction

  function automatic logic [TW-1:0] f_rd_hold(tcfg_t c);
    return c.relax ? TW'(8) : TW'(4);
  endfunction

  function automatic logic [TW-1:0] f_gap(tcfg_t c);
    return TW'((c.relax ? 32 : 16) * (2 + int'(c.cyc_len)));
  endfunction

  function automatic logic [TW-1:0] f_rb_delay(tcfg_t c);
    return TW'((c.relax ? 64 : 32) * (2 + int'(c.cyc_len)));
  endfunction
endpackage

// File: rtl/nfs_tcalc.sv
module nfs_tcalc
  import nfs_pkg::*;
(
  input  tcfg_t          cfg,
  input  kind_e          kind,
  output logic [TW-1:0]  gap_t,
  output logic [TW-1:0]  lead_t,
  output logic [TW-1:0]  strobe_t,
  output logic [TW-1:0]  hold_t,
  output logic [TW-1:0]  rbdly_t
);
  logic is_rd;
  assign is_rd    = (kind == K_RDATA);
  assign gap_t    = f_gap(cfg);
  assign lead_t   = f_cs_lead(cfg);
  assign strobe_t = is_rd ? f_re_low(cfg) : f_we_low(cfg);
  assign hold_t   = is_rd ? f_rd_hold(cfg) : f_we_hold(cfg);
  assign rbdly_t  = f_rb_delay(cfg);
endmodule

// File: rtl/nfs_fsm.sv
module nfs_fsm
  import nfs_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int TO_TICKS = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  kind_e            start_kind,
  input  kind_e            cur_kind,
  input  logic             rb_en,
  input  logic             rb_in,
  input  logic [TW-1:0]    gap_t,
  input  logic [TW-1:0]    lead_t,
  input  logic [TW-1:0]    strobe_t,
  input  logic [TW-1:0]    hold_t,
  input  logic [TW-1:0]    rbdly_t,
  output st_e              state,
  output st_e              nxt,
  output logic [CNT_W-1:0] cnt,
  output logic             phase_last,
  output logic             seq_end,
  output logic             to_hit,
  output logic             after_ca,
  output logic             done,
  output logic             timeout_err
);
  logic [CNT_W-1:0] lim;
  logic             start_is_data;

  assign start_is_data = (start_kind == K_WDATA) || (start_kind == K_RDATA);

  always_comb begin
    unique case (state)
      S_GAP:    lim = CNT_W'(gap_t);
      S_SETUP:  lim = CNT_W'(lead_t);
      S_STROBE: lim = CNT_W'(strobe_t);
      S_HOLD:   lim = CNT_W'(hold_t);
      S_RBWAIT: lim = CNT_W'(rbdly_t);
      S_RBPOLL: lim = CNT_W'(TO_TICKS);
      default:  lim = CNT_W'(1);
    endcase
  end

  assign phase_last = (cnt == lim - 1'b1);
  assign to_hit     = (state == S_RBPOLL) && !rb_in && phase_last;

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:   if (start) nxt = (start_is_data && after_ca) ? S_GAP : S_SETUP;
      S_GAP:    if (phase_last) nxt = S_SETUP;
      S_SETUP:  if (phase_last) nxt = S_STROBE;
      S_STROBE: if (phase_last) nxt = S_HOLD;
      S_HOLD:   if (phase_last) nxt = (cur_kind == K_CMD && rb_en) ? S_RBWAIT : S_IDLE;
      S_RBWAIT: if (phase_last) nxt = S_RBPOLL;
      S_RBPOLL: if (rb_in || phase_last) nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  assign seq_end = (state != S_IDLE) && (nxt == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      done        <= 1'b0;
      timeout_err <= 1'b0;
      after_ca    <= 1'b0;
    end else begin
      state       <= nxt;
      cnt         <= (nxt != state) ? '0 : cnt + 1'b1;
      done        <= seq_end;
      timeout_err <= to_hit;
      if (seq_end && (cur_kind == K_CMD || cur_kind == K_ADDR)) after_ca <= 1'b1;
      else if (start && start_is_data)                          after_ca <= 1'b0;
    end
  end
endmodule

// File: rtl/nfs_pins.sv
module nfs_pins
  import nfs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  st_e           state,
  input  st_e           nxt,
  input  logic          start,
  input  kind_e         kind,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] dq_in,
  output logic          cs_n,
  output logic          we_n,
  output logic          re_n,
  output logic          cle,
  output logic          ale,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          rd_capture
);
  logic nxt_active, nxt_drive, wr_kind;

  assign wr_kind    = (kind != K_RDATA);
  assign nxt_active = (nxt == S_GAP) || (nxt == S_SETUP) || (nxt == S_STROBE) || (nxt == S_HOLD);
  assign nxt_drive  = wr_kind && ((nxt == S_SETUP) || (nxt == S_STROBE) || (nxt == S_HOLD));
  assign rd_capture = (state == S_STROBE) && (nxt == S_HOLD) && !wr_kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n     <= 1'b1;
      we_n     <= 1'b1;
      re_n     <= 1'b1;
      cle      <= 1'b0;
      ale      <= 1'b0;
      dq_oe    <= 1'b0;
      dq_out   <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      cs_n     <= !nxt_active;
      we_n     <= !((nxt == S_STROBE) && wr_kind);
      re_n     <= !((nxt == S_STROBE) && !wr_kind);
      dq_oe    <= nxt_drive;
      cle      <= nxt_drive && (kind == K_CMD);
      ale      <= nxt_drive && (kind == K_ADDR);
      rd_valid <= rd_capture;
      if (start)      dq_out  <= wdata;
      if (rd_capture) rd_data <= dq_in;
    end
  end
endmodule

// File: rtl/nand_strobe_seq.sv
module nand_strobe_seq
  import nfs_pkg::*;
#(
  parameter int DW       = 8,
  parameter int TO_TICKS = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [5:0]    cfg_i,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_rb_wait,
  output logic          done,
  output logic          timeout_err,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          nf_cs_n,
  output logic          nf_we_n,
  output logic          nf_re_n,
  output logic          nf_cle,
  output logic          nf_ale,
  output logic [DW-1:0] nf_dq_out,
  output logic          nf_dq_oe,
  input  logic [DW-1:0] nf_dq_in,
  input  logic          nf_rb
);
  localparam int TO_BITS = $clog2(TO_TICKS + 1);
  localparam int CNT_W   = (TO_BITS > TW) ? TO_BITS : TW;

  st_e              st_cur, st_nxt;
  tcfg_t            cfg_q;
  kind_e            kind_q, kind_eff;
  logic             rbw_q, start;
  logic [TW-1:0]    gap_t, lead_t, strobe_t, hold_t, rbdly_t;
  logic [CNT_W-1:0] cnt;
  logic             phase_last, seq_end, to_hit, after_ca, rd_capture;

  assign req_ready = (st_cur == S_IDLE);
  assign start     = req_valid && req_ready;
  assign kind_eff  = start ? kind_e'(req_kind) : kind_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      kind_q <= K_CMD;
      rbw_q  <= 1'b0;
    end else if (start) begin
      cfg_q  <= tcfg_t'(cfg_i);
      kind_q <= kind_e'(req_kind);
      rbw_q  <= req_rb_wait;
    end
  end

  nfs_tcalc u_tcalc (
    .cfg(cfg_q), .kind(kind_q), .gap_t(gap_t), .lead_t(lead_t),
    .strobe_t(strobe_t), .hold_t(hold_t), .rbdly_t(rbdly_t)
  );

  nfs_fsm #(.CNT_W(CNT_W), .TO_TICKS(TO_TICKS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .start_kind(kind_e'(req_kind)),
    .cur_kind(kind_q), .rb_en(rbw_q), .rb_in(nf_rb),
    .gap_t(gap_t), .lead_t(lead_t), .strobe_t(strobe_t), .hold_t(hold_t), .rbdly_t(rbdly_t),
    .state(st_cur), .nxt(st_nxt), .cnt(cnt), .phase_last(phase_last), .seq_end(seq_end),
    .to_hit(to_hit), .after_ca(after_ca), .done(done), .timeout_err(timeout_err)
  );

  nfs_pins #(.DW(DW)) u_pins (
    .clk(clk), .rst_n(rst_n), .state(st_cur), .nxt(st_nxt), .start(start),
    .kind(kind_eff), .wdata(req_wdata), .dq_in(nf_dq_in),
    .cs_n(nf_cs_n), .we_n(nf_we_n), .re_n(nf_re_n), .cle(nf_cle), .ale(nf_ale),
    .dq_out(nf_dq_out), .dq_oe(nf_dq_oe), .rd_data(rd_data), .rd_valid(rd_valid),
    .rd_capture(rd_capture)
  );
endmodule

// File: rtl/nfs_seq_chk.sv
module nfs_seq_chk
  import nfs_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       done,
  input logic       timeout_err,
  input logic       rd_valid,
  input logic       cs_n,
  input logic       we_n,
  input logic       re_n,
  input logic       dq_oe,
  input st_e        state,
  input logic [5:0] cfg_q
);
  p_strobe_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));

  p_strobe_in_cs_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || !re_n) |-> !cs_n);

  p_rb_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RBWAIT || state == S_RBPOLL) |-> (cs_n && we_n && re_n));

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_rd_at_re_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $rose(re_n));

  p_wr_hold_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (dq_oe && !cs_n));

  p_err_with_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> done);

  p_cfg_frozen_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && $past(state) != S_IDLE) |-> $stable(cfg_q));
endmodule

bind nand_strobe_seq nfs_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .timeout_err(timeout_err), .rd_valid(rd_valid),
  .cs_n(nf_cs_n), .we_n(nf_we_n), .re_n(nf_re_n), .dq_oe(nf_dq_oe),
  .state(st_cur), .cfg_q(cfg_q)
);

// File: tb/sim_nand_strobe_seq.sv
`timescale 1ns/1ps
module sim_nand_strobe_seq;
  localparam int TO = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] cfg_i = '0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_kind = '0;
  logic [7:0] req_wdata = '0;
  logic       req_rb_wait = 1'b0;
  logic       done, timeout_err, rd_valid;
  logic [7:0] rd_data;
  logic       nf_cs_n, nf_we_n, nf_re_n, nf_cle, nf_ale, nf_dq_oe;
  logic [7:0] nf_dq_out;
  logic [7:0] nf_dq_in = '0;
  logic       nf_rb = 1'b1;

  always #2.5 clk = ~clk;

  nand_strobe_seq #(.DW(8), .TO_TICKS(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_wdata(req_wdata), .req_rb_wait(req_rb_wait),
    .done(done), .timeout_err(timeout_err), .rd_data(rd_data), .rd_valid(rd_valid),
    .nf_cs_n(nf_cs_n), .nf_we_n(nf_we_n), .nf_re_n(nf_re_n), .nf_cle(nf_cle), .nf_ale(nf_ale),
    .nf_dq_out(nf_dq_out), .nf_dq_oe(nf_dq_oe), .nf_dq_in(nf_dq_in), .nf_rb(nf_rb)
  );

  typedef struct {
    int lead; int low; int hold; int tail;
    bit err; bit is_rd; bit cle; bit ale; logic [7:0] dat;
    string t_lead; string t_low; string t_hold; string t_tail;
  } exp_t;

  exp_t q[$];
  int checks = 0, failures = 0;
  bit finished = 0;
  bit ca_flag = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // monitor: measures each bus cycle and compares at done
  int t = 0, t_csf = 0, t_sf = 0, t_sr = 0, t_csr = 0;
  bit pcs = 1, pwe = 1, pre = 1, poe = 0, oe_hold = 0, s_cle = 0, s_ale = 0;
  logic [7:0] s_dq = '0, got_rd = '0;
  int n_rdv = 0, n_done = 0, viol13 = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      exp_t e;
      t++;
      if (!nf_we_n && !nf_re_n) viol13++;
      if ((!nf_we_n || !nf_re_n) && nf_cs_n) viol13++;
      if (pcs && !nf_cs_n) t_csf = t;
      if (pwe && pre && (!nf_we_n || !nf_re_n)) begin
        t_sf = t; s_cle = nf_cle; s_ale = nf_ale; s_dq = nf_dq_out;
      end
      if ((!pwe && nf_we_n) || (!pre && nf_re_n)) t_sr = t;
      if (!pcs && nf_cs_n) begin t_csr = t; oe_hold = poe; end
      if (rd_valid) begin got_rd = rd_data; n_rdv++; end
      if (done) begin
        if (q.size() == 0) chk(0, "R2 unexpected done", 1, 0);
        else begin
          e = q.pop_front();
          chk(t_sf - t_csf == e.lead, e.t_lead, t_sf - t_csf, e.lead);
          chk(t_sr - t_sf == e.low, e.t_low, t_sr - t_sf, e.low);
          chk(t_csr - t_sr == e.hold, e.t_hold, t_csr - t_sr, e.hold);
          chk(t - t_csr == e.tail, e.t_tail, t - t_csr, e.tail);
          chk(timeout_err == e.err, "R12 err flag", int'(timeout_err), int'(e.err));
          if (e.is_rd) begin
            chk(got_rd == e.dat, "R8 rd_data", int'(got_rd), int'(e.dat));
            chk(n_rdv == 1, "R8 rd_valid count", n_rdv, 1);
            chk(oe_hold == 0, "R7 no drive", int'(oe_hold), 0);
          end else begin
            chk(s_cle == e.cle, "R10 cle", int'(s_cle), int'(e.cle));
            chk(s_ale == e.ale, "R10 ale", int'(s_ale), int'(e.ale));
            chk(s_dq == e.dat, "R10 dq_out", int'(s_dq), int'(e.dat));
            chk(oe_hold == 1, "R5 drive in hold", int'(oe_hold), 1);
          end
        end
        n_done++;
        n_rdv = 0;
      end
      pcs = nf_cs_n; pwe = nf_we_n; pre = nf_re_n; poe = nf_dq_oe;
    end
  end

  // driver: pushes expected item then issues the request
  task automatic run(input logic [1:0] k, input int scy, input bit rlx, input bit wh,
                     input bit rs, input logic [7:0] d, input bit rbw, input bit rbl,
                     input bit scr);
    exp_t e;
    int w, base, tgt;
    bit dat, rd, gap;
    w    = rlx ? scy + scy : scy;
    base = scy + 2;
    dat  = (k >= 2);
    rd   = (k == 3);
    gap  = dat && ca_flag;
    e.lead = (rlx ? 8 : 4) + (gap ? base * (rlx ? 32 : 16) : 0);
    if (rd) begin
      case ({rlx, rs})
        2'b00: e.low = 3;
        2'b01: e.low = 4;
        2'b10: e.low = 2;
        default: e.low = 4;
      endcase
      e.low  = e.low + 4 * w;
      e.hold = rlx ? 8 : 4;
    end else begin
      e.low = 4 * (w + 1);
      case ({rlx, wh})
        2'b00: e.hold = 2;
        2'b01: e.hold = 4;
        2'b10: e.hold = 6;
        default: e.hold = 8;
      endcase
    end
    if (k == 0 && rbw) e.tail = base * (rlx ? 64 : 32) + (rbl ? 1 : TO);
    else               e.tail = 0;
    e.err   = (k == 0) && rbw && !rbl;
    e.is_rd = rd;
    e.cle   = (k == 0);
    e.ale   = (k == 1);
    e.dat   = d;
    e.t_lead = scr ? "R14 lead" : (gap ? "R9 gap+lead" : "R3 cs lead");
    e.t_low  = scr ? "R14 strobe" : (rd ? "R6 re low" : "R4 we low");
    e.t_hold = scr ? "R14 hold" : (rd ? "R7 rd hold" : "R5 wr hold");
    e.t_tail = e.err ? "R12 timeout tail" : "R11 rb tail";
    ca_flag = !dat;
    q.push_back(e);
    tgt = n_done + 1;
    @(negedge clk);
    cfg_i = {rs, wh, rlx, 3'(scy)};
    req_kind = k; req_wdata = d; nf_dq_in = d;
    req_rb_wait = rbw; nf_rb = rbl;
    chk(req_ready == 1, "R2 ready idle", int'(req_ready), 1);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 0, "R2 busy", int'(req_ready), 0);
    if (scr) cfg_i = ~cfg_i;
    while (n_done < tgt) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(nf_cs_n && nf_we_n && nf_re_n, "R1 strobes idle", int'({nf_cs_n, nf_we_n, nf_re_n}), 7);
    chk(!nf_dq_oe && !nf_cle && !nf_ale, "R1 bus idle", int'({nf_dq_oe, nf_cle, nf_ale}), 0);
    chk(!done && !rd_valid && req_ready, "R1 handshake", int'({done, rd_valid, req_ready}), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    //   kind scy rlx wh rs data   rbw rbl scr
    run(2'd0, 0, 0, 0, 0, 8'h70, 0, 1, 0);
    run(2'd1, 3, 0, 1, 0, 8'h12, 0, 1, 0);
    run(2'd2, 3, 0, 0, 0, 8'hA5, 0, 1, 0);
    run(2'd2, 3, 0, 1, 0, 8'h5A, 0, 1, 0);
    run(2'd0, 2, 1, 0, 0, 8'h00, 0, 1, 0);
    run(2'd1, 7, 1, 1, 0, 8'hC3, 0, 1, 0);
    run(2'd3, 1, 1, 0, 0, 8'h96, 0, 1, 0);
    run(2'd3, 0, 0, 0, 0, 8'h3C, 0, 1, 0);
    run(2'd3, 2, 0, 0, 1, 8'hE1, 0, 1, 0);
    run(2'd3, 0, 1, 0, 1, 8'h1E, 0, 1, 0);
    run(2'd0, 1, 0, 0, 0, 8'hFF, 1, 1, 0);
    run(2'd0, 0, 0, 1, 0, 8'h90, 1, 0, 0);
    run(2'd2, 2, 0, 0, 0, 8'h4B, 0, 1, 1);
    run(2'd3, 1, 0, 1, 1, 8'h77, 0, 1, 1);
    chk(viol13 == 0, "R13 strobe overlap", viol13, 0);
    chk(q.size() == 0, "R2 missing done", q.size(), 0);
    finish_run();
  end
endmodule